// File: doc/BRIEF.md
# Interrupt Vectoring and Syndrome Unit

This block sits beside the fetch and retire stages of a core with 64-bit addresses. When the external priority logic has chosen an interrupt, it presents the winner for one cycle: a type code, the resume PC, the machine-state word, the faulting effective address, an exception-kind index and a flag that says whether a machine check came from an external signal. In the same edge the unit stores the return state and fault information, and it redirects fetch to a handler address. The handler address is built from a shared base register and a per-type offset register.

The unit also carries out the machine-check return. A `mc_return` pulse sends fetch back to the saved machine-check PC and reloads the saved machine-state word. Software reaches every register through a single-cycle special-register port, which has a write strobe, an index and a combinational read value. The base and offset registers have no reset value, so software must load them before the first interrupt.

Top module: `irq_vector_unit`

## Requirements
- R1: An accepted interrupt produces, on the next cycle, a one-cycle `redir_valid` with `msw_load` low. `redir_addr` is formed from the base field in bits 31:16, the selected offset field in bits 15:4, and zeros in bits 3:0 and 63:32. It uses the register contents from before that edge.
- R2: Type codes are: 0 critical input, 1 machine check, 2 data storage, 3 instruction storage, 4 external input, 5 alignment, 6 program, 7 floating-point unavailable, 8 system call, 9 data TLB miss. A request with type 7 or type 10 to 15 is not accepted. It produces no redirect and changes no register.
- R3: An accepted type 0 stores `irq_pc` and `irq_msw` in the critical pair. Type 1 stores them in the machine-check pair. Every other accepted type stores them in the standard pair. The other pairs keep their values.
- R4: An accepted machine check with `irq_ext_mc` low loads the machine-check address register from `irq_fault_addr`. With `irq_ext_mc` high, that register keeps its value.
- R5: Every accepted interrupt other than a machine check sets the syndrome register to a single 1 at bit position `irq_kind`, with all other bits 0. A machine check leaves the syndrome register unchanged.
- R6: The fault-address register loads `irq_fault_addr` only for types 2, 5 and 9. It keeps its value for every other type.
- R7: `mc_return` in a cycle with no accepted interrupt gives, on the next cycle, `redir_valid` and `msw_load` both high. `redir_addr` is then the saved machine-check PC and `msw_value` the saved machine-check state word. If an interrupt is accepted in the same cycle, the return is dropped and the interrupt is served.
- R8: Special-register indices are: 0 to 9 offset slot for that type, 16 base, 17 standard PC, 18 standard state, 19 critical PC, 20 critical state, 21 machine-check PC, 22 machine-check state, 23 machine-check address, 24 syndrome, 25 fault address.
- R8 (continued): The offset field is written from and read at data bits 15:4. The base field is written from and read at data bits 31:16. State words and the syndrome use bits 31:0. Every other read bit is zero. Slot 7 and indices 10 to 15 and 26 to 31 read zero and ignore writes.
- R9: When a special-register write targets a register that the same cycle's interrupt capture updates, the capture value is kept. A write to any other register in that cycle still takes effect.
- R10: After reset, `redir_valid` and `msw_load` are low, and the save pairs, machine-check address, syndrome and fault-address registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_valid | input | 1 | Prioritized interrupt request, one cycle per request |
| irq_type | input | 4 | Interrupt type code |
| irq_pc | input | 64 | Resume address to save |
| irq_msw | input | 32 | Machine-state word to save |
| irq_fault_addr | input | 64 | Faulting effective address |
| irq_kind | input | 5 | Bit index of the exception kind for the syndrome |
| irq_ext_mc | input | 1 | Machine check raised by an external signal |
| mc_return | input | 1 | Machine-check return instruction executes |
| spr_we | input | 1 | Special-register write strobe |
| spr_idx | input | 5 | Special-register index |
| spr_wdata | input | 64 | Special-register write data |
| spr_rdata | output | 64 | Special-register read data for `spr_idx` |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_addr | output | 64 | Redirect target |
| msw_load | output | 1 | Machine-state restore pulse |
| msw_value | output | 32 | Machine-state word to restore |

## Verification
The assertions assume the request inputs are single-cycle pulses decided by upstream priority logic. They also assume `irq_kind` always names a bit inside the syndrome width, which holds by port width at the default size. They do not check that base and offset were loaded before the first request. The stimulus meets this by writing the base and every offset slot right after reset, before any request. Later base and offset rewrites in the mixed phase carry fully defined data. The mixed phase draws the type, kind, write index and return strobe from their full port ranges. This places collisions of writes, captures and returns on the same edge inside the covered space.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
   localparam int TYPE_W = 4;
   localparam int IDX_W  = 5;

   typedef enum logic [TYPE_W-1:0] {
      IT_CRIT  = 4'd0,
      IT_MCHK  = 4'd1,
      IT_DSTOR = 4'd2,
      IT_ISTOR = 4'd3,
      IT_EXT   = 4'd4,
      IT_ALIGN = 4'd5,
      IT_PROG  = 4'd6,
      IT_FPU   = 4'd7,
      IT_SCALL = 4'd8,
      IT_DTLB  = 4'd9
   } itype_e;

   localparam int DEF_TYPES = 10;
   localparam logic [DEF_TYPES-1:0] DEF_UNSUP = 10'b00_1000_0000;

   typedef enum logic [IDX_W-1:0] {
      SR_BASE  = 5'd16,
      SR_RPC   = 5'd17,
      SR_RMSW  = 5'd18,
      SR_CPC   = 5'd19,
      SR_CMSW  = 5'd20,
      SR_MPC   = 5'd21,
      SR_MMSW  = 5'd22,
      SR_MADDR = 5'd23,
      SR_SYN   = 5'd24,
      SR_FADDR = 5'd25
   } sr_idx_e;

   typedef enum logic [1:0] {
      PAIR_STD  = 2'd0,
      PAIR_CRIT = 2'd1,
      PAIR_MCHK = 2'd2
   } pair_e;
endpackage

// File: rtl/ivu_offset_bank.sv
module ivu_offset_bank
   import ivu_pkg::*;
#(
   parameter int                   N_TYPES = DEF_TYPES,
   parameter int                   OFS_W   = 12,
   parameter logic [N_TYPES-1:0]   UNSUP   = DEF_UNSUP
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [TYPE_W-1:0] wr_slot,
   input  logic [OFS_W-1:0]  wr_field,
   input  logic [TYPE_W-1:0] sel_type,
   output logic              sel_ok,
   output logic [OFS_W-1:0]  sel_field,
   input  logic [TYPE_W-1:0] rd_slot,
   output logic [OFS_W-1:0]  rd_field
);
   logic [N_TYPES-1:0][OFS_W-1:0] slot_q;

   for (genvar g = 0; g < N_TYPES; g++) begin : g_slot
      if (UNSUP[g]) begin : g_absent
         assign slot_q[g] = '0;
      end else begin : g_present
         logic [OFS_W-1:0] q;
         always_ff @(posedge clk) begin
            if (wr_en && wr_slot == TYPE_W'(g)) q <= wr_field;
         end
         assign slot_q[g] = q;
      end
   end

   always_comb begin
      sel_ok    = 1'b0;
      sel_field = '0;
      rd_field  = '0;
      for (int i = 0; i < N_TYPES; i++) begin
         if (sel_type == TYPE_W'(i) && !UNSUP[i]) begin
            sel_ok    = 1'b1;
            sel_field = slot_q[i];
         end
         if (rd_slot == TYPE_W'(i)) rd_field = slot_q[i];
      end
   end
endmodule

// File: rtl/ivu_capture.sv
module ivu_capture
   import ivu_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int MSW_W  = 32,
   parameter int SYN_W  = 32,
   localparam int KIND_W = $clog2(SYN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  pair_e             pair,
   input  logic [TYPE_W-1:0] cap_type,
   input  logic [ADDR_W-1:0] cap_pc,
   input  logic [MSW_W-1:0]  cap_msw,
   input  logic [ADDR_W-1:0] cap_faddr,
   input  logic [KIND_W-1:0] cap_kind,
   input  logic              cap_ext,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mc_pc,
   output logic [MSW_W-1:0]  mc_msw
);
   logic [ADDR_W-1:0] rpc_q, cpc_q, mpc_q, maddr_q, faddr_q;
   logic [MSW_W-1:0]  rmsw_q, cmsw_q, mmsw_q;
   logic [SYN_W-1:0]  syn_q;

   logic w_rpc, w_rmsw, w_cpc, w_cmsw, w_mpc, w_mmsw, w_maddr, w_syn, w_faddr;
   assign w_rpc   = wr_en && wr_idx == SR_RPC;
   assign w_rmsw  = wr_en && wr_idx == SR_RMSW;
   assign w_cpc   = wr_en && wr_idx == SR_CPC;
   assign w_cmsw  = wr_en && wr_idx == SR_CMSW;
   assign w_mpc   = wr_en && wr_idx == SR_MPC;
   assign w_mmsw  = wr_en && wr_idx == SR_MMSW;
   assign w_maddr = wr_en && wr_idx == SR_MADDR;
   assign w_syn   = wr_en && wr_idx == SR_SYN;
   assign w_faddr = wr_en && wr_idx == SR_FADDR;

   logic c_std, c_crit, c_mchk, c_syn, c_maddr, c_faddr, fault_type;
   assign fault_type = cap_type == IT_DSTOR || cap_type == IT_ALIGN || cap_type == IT_DTLB;
   assign c_std   = take && pair == PAIR_STD;
   assign c_crit  = take && pair == PAIR_CRIT;
   assign c_mchk  = take && pair == PAIR_MCHK;
   assign c_syn   = take && pair != PAIR_MCHK;
   assign c_maddr = c_mchk && !cap_ext;
   assign c_faddr = take && fault_type;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpc_q <= '0; rmsw_q <= '0; cpc_q <= '0; cmsw_q <= '0;
         mpc_q <= '0; mmsw_q <= '0; maddr_q <= '0; syn_q <= '0; faddr_q <= '0;
      end else begin
         if (c_std) begin
            rpc_q <= cap_pc; rmsw_q <= cap_msw;
         end else begin
            if (w_rpc)  rpc_q  <= wr_data;
            if (w_rmsw) rmsw_q <= wr_data[MSW_W-1:0];
         end
         if (c_crit) begin
            cpc_q <= cap_pc; cmsw_q <= cap_msw;
         end else begin
            if (w_cpc)  cpc_q  <= wr_data;
            if (w_cmsw) cmsw_q <= wr_data[MSW_W-1:0];
         end
         if (c_mchk) begin
            mpc_q <= cap_pc; mmsw_q <= cap_msw;
         end else begin
            if (w_mpc)  mpc_q  <= wr_data;
            if (w_mmsw) mmsw_q <= wr_data[MSW_W-1:0];
         end
         if (c_maddr)      maddr_q <= cap_faddr;
         else if (w_maddr) maddr_q <= wr_data;
         if (c_syn)        syn_q   <= SYN_W'(1) << cap_kind;
         else if (w_syn)   syn_q   <= wr_data[SYN_W-1:0];
         if (c_faddr)      faddr_q <= cap_faddr;
         else if (w_faddr) faddr_q <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_idx)
         SR_RPC:   rd_data = rpc_q;
         SR_RMSW:  rd_data = ADDR_W'(rmsw_q);
         SR_CPC:   rd_data = cpc_q;
         SR_CMSW:  rd_data = ADDR_W'(cmsw_q);
         SR_MPC:   rd_data = mpc_q;
         SR_MMSW:  rd_data = ADDR_W'(mmsw_q);
         SR_MADDR: rd_data = maddr_q;
         SR_SYN:   rd_data = ADDR_W'(syn_q);
         SR_FADDR: rd_data = faddr_q;
         default:  rd_data = '0;
      endcase
   end

   assign mc_pc  = mpc_q;
   assign mc_msw = mmsw_q;

   // R5: a non-machine-check capture leaves exactly one syndrome bit set
   p_syn_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pair != PAIR_MCHK) |=> ($countones(syn_q) == 1));
   // R4: externally signalled machine check keeps the address register
   p_maddr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pair == PAIR_MCHK && cap_ext && !w_maddr) |=> $stable(maddr_q));
   // R6: non-fault types keep the fault address
   p_faddr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !fault_type && !w_faddr) |=> $stable(faddr_q));
   // R3: a standard capture leaves the critical pair alone
   p_pair_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pair == PAIR_STD && !w_cpc && !w_cmsw) |=> ($stable(cpc_q) && $stable(cmsw_q)));
   // R9: capture value wins over a colliding write
   p_cap_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pair == PAIR_STD) |=> (rpc_q == $past(cap_pc)));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import ivu_pkg::*;
#(
   parameter int                  ADDR_W     = 64,
   parameter int                  MSW_W      = 32,
   parameter int                  SYN_W      = 32,
   parameter int                  PFX_W      = 16,
   parameter int                  OFS_W      = 12,
   parameter int                  ALIGN_W    = 4,
   parameter int                  N_TYPES    = DEF_TYPES,
   parameter logic [N_TYPES-1:0]  UNSUP_MASK = DEF_UNSUP,
   localparam int                 KIND_W     = $clog2(SYN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_valid,
   input  logic [TYPE_W-1:0] irq_type,
   input  logic [ADDR_W-1:0] irq_pc,
   input  logic [MSW_W-1:0]  irq_msw,
   input  logic [ADDR_W-1:0] irq_fault_addr,
   input  logic [KIND_W-1:0] irq_kind,
   input  logic              irq_ext_mc,
   input  logic              mc_return,
   input  logic              spr_we,
   input  logic [IDX_W-1:0]  spr_idx,
   input  logic [ADDR_W-1:0] spr_wdata,
   output logic [ADDR_W-1:0] spr_rdata,
   output logic              redir_valid,
   output logic [ADDR_W-1:0] redir_addr,
   output logic              msw_load,
   output logic [MSW_W-1:0]  msw_value
);
   localparam int VEC_W   = PFX_W + OFS_W + ALIGN_W;
   localparam int PFX_LSB = OFS_W + ALIGN_W;
   localparam logic [IDX_W-1:0] SLOT_LIM = IDX_W'(N_TYPES);

   if (VEC_W > ADDR_W) begin : g_bad_vec
      $error("vector fields exceed address width");
   end
   if (MSW_W > ADDR_W || SYN_W > ADDR_W) begin : g_bad_word
      $error("state or syndrome wider than data port");
   end
   if (N_TYPES < 2 || N_TYPES > 16) begin : g_bad_types
      $error("type count must lie in 2..16");
   end
   if (UNSUP_MASK[0] || UNSUP_MASK[1]) begin : g_bad_mask
      $error("critical and machine-check slots must be supported");
   end

   logic              sel_ok, slot_hit;
   logic [OFS_W-1:0]  sel_field, bank_rd;
   logic [PFX_W-1:0]  base_q;
   logic [ADDR_W-1:0] vec, cap_rd, mc_pc;
   logic [MSW_W-1:0]  mc_msw;
   logic              take;
   pair_e             pair;

   assign slot_hit = spr_idx < SLOT_LIM;

   ivu_offset_bank #(.N_TYPES(N_TYPES), .OFS_W(OFS_W), .UNSUP(UNSUP_MASK)) u_bank (
      .clk      (clk),
      .wr_en    (spr_we && slot_hit),
      .wr_slot  (spr_idx[TYPE_W-1:0]),
      .wr_field (spr_wdata[ALIGN_W +: OFS_W]),
      .sel_type (irq_type),
      .sel_ok   (sel_ok),
      .sel_field(sel_field),
      .rd_slot  (spr_idx[TYPE_W-1:0]),
      .rd_field (bank_rd)
   );

   always_ff @(posedge clk) begin
      if (spr_we && spr_idx == SR_BASE) base_q <= spr_wdata[PFX_LSB +: PFX_W];
   end

   assign take = irq_valid && sel_ok;
   assign vec  = ADDR_W'({base_q, sel_field, {ALIGN_W{1'b0}}});

   always_comb begin
      pair = PAIR_STD;
      if (irq_type == IT_CRIT)      pair = PAIR_CRIT;
      else if (irq_type == IT_MCHK) pair = PAIR_MCHK;
   end

   ivu_capture #(.ADDR_W(ADDR_W), .MSW_W(MSW_W), .SYN_W(SYN_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .pair     (pair),
      .cap_type (irq_type),
      .cap_pc   (irq_pc),
      .cap_msw  (irq_msw),
      .cap_faddr(irq_fault_addr),
      .cap_kind (irq_kind),
      .cap_ext  (irq_ext_mc),
      .wr_en    (spr_we),
      .wr_idx   (spr_idx),
      .wr_data  (spr_wdata),
      .rd_idx   (spr_idx),
      .rd_data  (cap_rd),
      .mc_pc    (mc_pc),
      .mc_msw   (mc_msw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redir_valid <= 1'b0;
         msw_load    <= 1'b0;
         redir_addr  <= '0;
         msw_value   <= '0;
      end else begin
         redir_valid <= take || mc_return;
         msw_load    <= !take && mc_return;
         if (take)           redir_addr <= vec;
         else if (mc_return) redir_addr <= mc_pc;
         if (!take && mc_return) msw_value <= mc_msw;
      end
   end

   always_comb begin
      if (slot_hit)                spr_rdata = ADDR_W'({bank_rd, {ALIGN_W{1'b0}}});
      else if (spr_idx == SR_BASE) spr_rdata = ADDR_W'({base_q, {PFX_LSB{1'b0}}});
      else                         spr_rdata = cap_rd;
   end

   // R1: interrupt redirects are aligned and confined to the vector field width
   p_vec_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_valid && !msw_load) |-> (redir_addr[ALIGN_W-1:0] == '0 && (redir_addr >> VEC_W) == '0));
   // R2: a rejected request with no return pending yields no redirect
   p_unsup_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !sel_ok && !mc_return) |=> !redir_valid);
   // R7: a lone return restores both PC and state
   p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_return && !take) |=> (redir_valid && msw_load));
   // R7: an accepted interrupt suppresses the state restore
   p_irq_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (redir_valid && !msw_load));
endmodule

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_valid = 1'b0;
   logic [3:0]  irq_type = '0;
   logic [63:0] irq_pc = '0;
   logic [31:0] irq_msw = '0;
   logic [63:0] irq_fault_addr = '0;
   logic [4:0]  irq_kind = '0;
   logic        irq_ext_mc = 1'b0;
   logic        mc_return = 1'b0;
   logic        spr_we = 1'b0;
   logic [4:0]  spr_idx = 5'd17;
   logic [63:0] spr_wdata = '0;
   logic [63:0] spr_rdata;
   logic        redir_valid, msw_load;
   logic [63:0] redir_addr;
   logic [31:0] msw_value;

   always #2.5 clk = ~clk;

   irq_vector_unit u0 (
      .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_type(irq_type),
      .irq_pc(irq_pc), .irq_msw(irq_msw), .irq_fault_addr(irq_fault_addr),
      .irq_kind(irq_kind), .irq_ext_mc(irq_ext_mc), .mc_return(mc_return),
      .spr_we(spr_we), .spr_idx(spr_idx), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
      .redir_valid(redir_valid), .redir_addr(redir_addr),
      .msw_load(msw_load), .msw_value(msw_value)
   );

   // behavioural reference state
   logic [15:0] m_base = '0;
   logic [11:0] m_off [10];
   logic [63:0] m_rpc, m_cpc, m_mpc, m_maddr, m_fault;
   logic [31:0] m_rmsw, m_cmsw, m_mmsw, m_syn;
   logic        e_rv, e_ml;
   logic [63:0] e_ra;
   logic [31:0] e_mv;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;
   string tag = "R10";

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_read(input logic [4:0] i);
      if (i < 5'd10) return (i == 5'd7) ? 64'd0 : {48'd0, m_off[i], 4'd0};
      case (i)
         5'd16: return {32'd0, m_base, 16'd0};
         5'd17: return m_rpc;
         5'd18: return {32'd0, m_rmsw};
         5'd19: return m_cpc;
         5'd20: return {32'd0, m_cmsw};
         5'd21: return m_mpc;
         5'd22: return {32'd0, m_mmsw};
         5'd23: return m_maddr;
         5'd24: return {32'd0, m_syn};
         5'd25: return m_fault;
         default: return 64'd0;
      endcase
   endfunction

   task automatic model_edge();
      bit acc;
      if (!rst_n) begin
         m_rpc = 0; m_cpc = 0; m_mpc = 0; m_maddr = 0; m_fault = 0;
         m_rmsw = 0; m_cmsw = 0; m_mmsw = 0; m_syn = 0;
         e_rv = 0; e_ml = 0;
         return;
      end
      acc = irq_valid && irq_type < 4'd10 && irq_type != 4'd7;
      e_rv = acc || mc_return;
      e_ml = !acc && mc_return;
      if (acc) e_ra = {32'd0, m_base, m_off[irq_type], 4'd0};
      else if (mc_return) e_ra = m_mpc;
      if (e_ml) e_mv = m_mmsw;
      if (spr_we) begin
         if (spr_idx < 5'd10 && spr_idx != 5'd7) m_off[spr_idx] = spr_wdata[15:4];
         case (spr_idx)
            5'd16: m_base = spr_wdata[31:16];
            5'd17: m_rpc = spr_wdata;
            5'd18: m_rmsw = spr_wdata[31:0];
            5'd19: m_cpc = spr_wdata;
            5'd20: m_cmsw = spr_wdata[31:0];
            5'd21: m_mpc = spr_wdata;
            5'd22: m_mmsw = spr_wdata[31:0];
            5'd23: m_maddr = spr_wdata;
            5'd24: m_syn = spr_wdata[31:0];
            5'd25: m_fault = spr_wdata;
            default: ;
         endcase
      end
      if (acc) begin
         if (irq_type == 4'd0) begin m_cpc = irq_pc; m_cmsw = irq_msw; end
         else if (irq_type == 4'd1) begin
            m_mpc = irq_pc; m_mmsw = irq_msw;
            if (!irq_ext_mc) m_maddr = irq_fault_addr;
         end else begin m_rpc = irq_pc; m_rmsw = irq_msw; end
         if (irq_type != 4'd1) m_syn = 32'd1 << irq_kind;
         if (irq_type == 4'd2 || irq_type == 4'd5 || irq_type == 4'd9) m_fault = irq_fault_addr;
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(redir_valid === e_rv, "redirect valid", 64'(redir_valid), 64'(e_rv));
      if (e_rv) chk(redir_addr === e_ra, "redirect address", redir_addr, e_ra);
      chk(msw_load === e_ml, "state load", 64'(msw_load), 64'(e_ml));
      if (e_ml) chk(msw_value === e_mv, "state value", 64'(msw_value), 64'(e_mv));
      chk(spr_rdata === exp_read(spr_idx), "register read", spr_rdata, exp_read(spr_idx));
      irq_valid = 0; mc_return = 0; spr_we = 0;
   endtask

   task automatic wr(input logic [4:0] i, input logic [63:0] d);
      spr_we = 1; spr_idx = i; spr_wdata = d; cyc();
   endtask

   task automatic rd(input logic [4:0] i);
      spr_idx = i; cyc();
   endtask

   task automatic fire(input logic [3:0] t, input logic [63:0] pc, input logic [31:0] ms,
                       input logic [63:0] fa, input logic [4:0] k, input logic ext);
      irq_valid = 1; irq_type = t; irq_pc = pc; irq_msw = ms;
      irq_fault_addr = fa; irq_kind = k; irq_ext_mc = ext; cyc();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 10; i++) m_off[i] = '0;
      // R10: reset state of outputs and capture registers
      tag = "R10";
      for (int i = 17; i <= 25; i++) rd(5'(i));
      @(negedge clk); rst_n = 1;

      // R8: base and offset layout, unimplemented indices
      tag = "R8";
      wr(5'd16, 64'hFFFF_FFFF_1234_ABCD);
      for (int i = 0; i < 10; i++) wr(5'(i), 64'hDEAD_0000_0000_000F | (64'(12'h100 + i * 12'h23) << 4));
      rd(5'd7);
      for (int i = 10; i < 16; i++) rd(5'(i));
      wr(5'd30, 64'hFFFF_FFFF_FFFF_FFFF); rd(5'd30); rd(5'd26);
      wr(5'd18, 64'hAAAA_BBBB_CCCC_DDDD); rd(5'd18);

      // R1: vector formation, including a base change
      tag = "R1";
      fire(4'd4, 64'h1000, 32'h11, 64'h0, 5'd3, 1'b0);
      fire(4'd8, 64'h2000, 32'h22, 64'h0, 5'd4, 1'b0);
      wr(5'd16, 64'h0000_0000_FFFF_0000);
      fire(4'd6, 64'h3000, 32'h33, 64'h0, 5'd5, 1'b0);

      // R2: every type code, accepted or rejected
      tag = "R2";
      for (int t = 0; t < 16; t++) begin
         fire(4'(t), 64'h5000 + 64'(t), 32'h500 + 32'(t), 64'h9000 + 64'(t), 5'(t), 1'b0);
         rd(5'd17); rd(5'd25);
      end

      // R3: pair selection
      tag = "R3";
      fire(4'd0, 64'hC0C0, 32'hC1, 64'h1, 5'd1, 1'b0); rd(5'd19); rd(5'd20); rd(5'd17);
      fire(4'd1, 64'hB0B0, 32'hB1, 64'h2, 5'd2, 1'b0); rd(5'd21); rd(5'd22); rd(5'd19);
      fire(4'd3, 64'hA0A0, 32'hA1, 64'h3, 5'd3, 1'b0); rd(5'd17); rd(5'd18); rd(5'd21);

      // R4: machine-check address capture rules
      tag = "R4";
      fire(4'd1, 64'h77, 32'h7, 64'hFACE_0000, 5'd0, 1'b0); rd(5'd23);
      fire(4'd1, 64'h78, 32'h8, 64'hBEEF_0000, 5'd0, 1'b1); rd(5'd23);

      // R5: syndrome one-hot, untouched by machine check
      tag = "R5";
      fire(4'd6, 64'h1, 32'h1, 64'h0, 5'd0, 1'b0); rd(5'd24);
      fire(4'd6, 64'h2, 32'h1, 64'h0, 5'd31, 1'b0); rd(5'd24);
      fire(4'd1, 64'h3, 32'h1, 64'h0, 5'd13, 1'b0); rd(5'd24);

      // R6: fault address only for data storage, alignment, data TLB miss
      tag = "R6";
      fire(4'd2, 64'h1, 32'h1, 64'hD5D5, 5'd1, 1'b0); rd(5'd25);
      fire(4'd3, 64'h1, 32'h1, 64'h3333, 5'd1, 1'b0); rd(5'd25);
      fire(4'd5, 64'h1, 32'h1, 64'hA5A5, 5'd1, 1'b0); rd(5'd25);
      fire(4'd4, 64'h1, 32'h1, 64'h4444, 5'd1, 1'b0); rd(5'd25);
      fire(4'd9, 64'h1, 32'h1, 64'h9D9D, 5'd1, 1'b0); rd(5'd25);

      // R7: machine-check return and its collision with an interrupt
      tag = "R7";
      wr(5'd21, 64'h0123_4567_89AB_CDE0); wr(5'd22, 64'h0000_0000_5A5A_A5A5);
      mc_return = 1; cyc(); rd(5'd21);
      mc_return = 1; fire(4'd8, 64'hE0, 32'hE1, 64'h0, 5'd2, 1'b0);
      mc_return = 1; fire(4'd7, 64'hE0, 32'hE1, 64'h0, 5'd2, 1'b0);

      // R9: write/capture collision
      tag = "R9";
      spr_we = 1; spr_idx = 5'd17; spr_wdata = 64'hFFFF_0000_FFFF_0000;
      fire(4'd4, 64'h4242, 32'h42, 64'h0, 5'd6, 1'b0); rd(5'd17);
      spr_we = 1; spr_idx = 5'd19; spr_wdata = 64'h1919_1919_1919_1919;
      fire(4'd4, 64'h4343, 32'h43, 64'h0, 5'd7, 1'b0); rd(5'd19);

      // R2: mixed traffic over the full input ranges
      tag = "R2";
      for (int n = 0; n < 400; n++) begin
         irq_valid = ($urandom % 3) == 0;
         irq_type = 4'($urandom);
         irq_pc = {$urandom, $urandom};
         irq_msw = $urandom;
         irq_fault_addr = {$urandom, $urandom};
         irq_kind = 5'($urandom);
         irq_ext_mc = 1'($urandom);
         mc_return = ($urandom % 4) == 0;
         spr_we = ($urandom % 4) == 0;
         spr_idx = 5'($urandom);
         spr_wdata = {$urandom, $urandom};
         cyc();
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule